// File: doc/BRIEF.md
# PCI Target Claim Decoder

This block sits beside a bridge on a 33 MHz PCI bus and decides whether the bridge takes each bus cycle by driving DEVSEL# low, and in which clock it does so. At the start of every transaction it captures the address, the command and the decode mode. In positive mode it claims only cycles that fall in a programmed address window, and it claims them at medium decode timing. In subtractive mode it waits until every faster agent has had a chance to respond, and it claims a cycle only if no other agent has driven DEVSEL#.

Some I/O cycles are aimed at functions that sit next to the bridge and complete without going onto the bus. An address-phase qualifier marks these cycles, and the block never claims them. Configuration cycles to the same functions still go through the normal decode. When the block is in subtractive mode and another agent claims a boot-region memory read, a sticky flag records the event. Software clears the flag through a small write-one-to-clear status port.

Top module: `pci_claim_ctl`

## Requirements
- R1: While reset is held, DEVSEL# (`devsel_n`) is high and the whole status byte reads zero.
- R2: The address, the command and the mode bit are sampled on the first clock edge that sees FRAME# low while the block is idle. Later changes to `ad`, `cbe_n` or `decode_subtr` during that transaction have no effect on it.
- R3: In positive mode (`decode_subtr`=0), a claimable command whose address satisfies `win_base` <= address <= `win_limit` drives `devsel_n` low from the second clock after the address phase. Any other address leaves `devsel_n` high.
- R4: In subtractive mode (`decode_subtr`=1), a claimable command that sees no external DEVSEL# drives `devsel_n` low from the fourth clock after the address phase, and not earlier.
- R5: In subtractive mode, if `ext_devsel_n` is sampled low on any of the three clocks after the address phase, the block never drives `devsel_n` low for that transaction.
- R6: I/O commands (C/BE# 0010, 0011) that carry `local_io_hit`=1 are never claimed in either mode. Configuration commands (1010, 1011) are decoded the same whatever `local_io_hit` is.
- R7: Only commands 0010, 0011, 0110, 0111, 1010, 1011, 1100, 1110 and 1111 are claimable. No other command value is ever claimed.
- R8: Once asserted, `devsel_n` stays low until a clock edge that samples FRAME# high, IRDY# low and TRDY# low. It is high after that edge.
- R9: Status bit 2 is set when, in subtractive mode, an external agent claims a memory read (0110, 1100 or 1110) whose address lies inside the boot window `BOOT_BASE`..`BOOT_LIMIT`. Once set, the bit stays set.
- R10: A status write with bit 2 = 1 clears bit 2. A write with bit 2 = 0 leaves it unchanged. All other status bits always read zero.
- R11: If a set event and a clearing write fall on the same clock edge, bit 2 ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | FRAME# as seen on the bus |
| irdy_n | input | 1 | IRDY# as seen on the bus |
| trdy_n | input | 1 | TRDY# as seen on the bus |
| ext_devsel_n | input | 1 | DEVSEL# driven by other agents |
| ad | input | ADDR_W | Address/data bus |
| cbe_n | input | 4 | Command / byte enables |
| local_io_hit | input | 1 | Address-phase qualifier: the I/O cycle is served internally |
| decode_subtr | input | 1 | 0 = positive decode, 1 = subtractive decode |
| win_base | input | ADDR_W | Lowest address of the positive window |
| win_limit | input | ADDR_W | Highest address of the positive window |
| sts_wr_en | input | 1 | Status write strobe |
| sts_wdata | input | STS_W | Status write data, write-one-to-clear |
| devsel_n | output | 1 | Claim output (DEVSEL#, active low) |
| status | output | STS_W | Status byte, boot flag in bit 2 |

## Verification
The boot flag can be set by an external claim and cleared by a software write on the same clock edge. The sweep provokes this by pulsing the clearing write on the exact edge where the external DEVSEL# is first sampled, for every command and every address point. The expected result is computed as set-wins: after any boot-window read the flag stays 1, and after any other cycle it drops to 0. Each transaction then ends with a write of zero to the bit, followed by a write of one, so the flag's value is checked at the ports on every pass.

// File: rtl/pci_claim_pkg.sv
// Package: shared state type, timing constants and command classifiers
// for the PCI claim decoder. Command codes are the raw C/BE# values
// driven during the address phase.
package pci_claim_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECODE = 2'd1,
        ST_CLAIM  = 2'd2,
        ST_WAIT   = 2'd3
    } claim_state_e;

    // Clock (counted from the address phase) in which a subtractive claim is first visible.
    localparam int SUB_VISIBLE_CLK = 4;
    // Decode-state counter value at the edge that launches the subtractive claim.
    localparam int SUB_LAUNCH_CNT  = SUB_VISIBLE_CLK - 2;
    localparam int CNT_W           = 2;

    // True for commands this bridge may ever take.
    function automatic logic cmd_claimable(input logic [3:0] cmd);
        case (cmd)
            4'b0010, 4'b0011,                   // I/O read / write
            4'b0110, 4'b0111,                   // memory read / write
            4'b1010, 4'b1011,                   // configuration read / write
            4'b1100, 4'b1110, 4'b1111: return 1'b1; // memory multiple/line/invalidate
            default:                   return 1'b0;
        endcase
    endfunction

    function automatic logic cmd_is_io(input logic [3:0] cmd);
        return cmd[3:1] == 3'b001;
    endfunction

    function automatic logic cmd_is_mem_read(input logic [3:0] cmd);
        return (cmd == 4'b0110) || (cmd == 4'b1100) || (cmd == 4'b1110);
    endfunction

endpackage

// File: rtl/pci_win_cmp.sv
// Module: pci_win_cmp
// Inclusive address window compare: hit when lo <= addr <= hi.
// Assumes lo <= hi; an inverted window never hits.
module pci_win_cmp #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    output logic              hit
);

    // Both ends are part of the window.
    always_comb begin
        hit = (addr >= lo) && (addr <= hi);
    end

endmodule

// File: rtl/pci_claim_decode.sv
// Module: pci_claim_decode
// Combinational decode of a captured address phase. It produces the
// positive-window hit, the subtractive eligibility and the boot-window read
// flag. Assumes its inputs are held stable for the whole transaction.
module pci_claim_decode
    import pci_claim_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] BOOT_BASE  = 32'hFFFF_0000,
    parameter logic [ADDR_W-1:0] BOOT_LIMIT = 32'hFFFF_FFFF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        cmd,
    input  logic              local_io,
    input  logic [ADDR_W-1:0] win_base,
    input  logic [ADDR_W-1:0] win_limit,
    output logic              pos_hit,
    output logic              sub_ok,
    output logic              boot_hit
);

    localparam int NWIN = 2;   // index 0: programmed window, 1: boot window

    logic [ADDR_W-1:0] win_lo [NWIN];
    logic [ADDR_W-1:0] win_hi [NWIN];
    logic [NWIN-1:0]   win_hit;
    logic              eligible;

    // Gather window bounds so the compare instances come from one loop.
    always_comb begin
        win_lo[0] = win_base;
        win_hi[0] = win_limit;
        win_lo[1] = BOOT_BASE;
        win_hi[1] = BOOT_LIMIT;
    end

    generate
        for (genvar w = 0; w < NWIN; w++) begin : g_win
            pci_win_cmp #(.ADDR_W(ADDR_W)) u_cmp (
                .addr (addr),
                .lo   (win_lo[w]),
                .hi   (win_hi[w]),
                .hit  (win_hit[w])
            );
        end
    endgenerate

    // Claimable command not diverted to an internal function.
    always_comb begin
        eligible = cmd_claimable(cmd) && !(cmd_is_io(cmd) && local_io);
        pos_hit  = eligible && win_hit[0];
        sub_ok   = eligible;
        boot_hit = cmd_is_mem_read(cmd) && win_hit[1];
    end

endmodule

// File: rtl/pci_claim_fsm.sv
// Module: pci_claim_fsm
// Follows bus phases. It captures the address phase, times the medium or
// subtractive claim, holds DEVSEL# until the final data phase completes and
// flags external claims of boot reads. Assumes the decode results are a
// combinational function of the captured values it provides.
module pci_claim_fsm
    import pci_claim_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic              trdy_n,
    input  logic              ext_devsel_n,
    input  logic [ADDR_W-1:0] ad,
    input  logic [3:0]        cbe_n,
    input  logic              local_io_hit,
    input  logic              decode_subtr,
    input  logic              pos_hit,
    input  logic              sub_ok,
    input  logic              boot_hit,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [3:0]        cap_cmd,
    output logic              cap_lio,
    output logic              mode_q,
    output logic              devsel_n,
    output logic              boot_set
);

    claim_state_e     state;
    logic [CNT_W-1:0] cnt;
    logic             bus_idle;
    logic             last_done;

    // Bus-level conditions used by several states.
    always_comb begin
        bus_idle  = frame_n && irdy_n;
        last_done = frame_n && !irdy_n && !trdy_n;
    end

    // Boot flag event: an external agent took a boot read during a subtractive window.
    always_comb begin
        boot_set = (state == ST_DECODE) && mode_q && !bus_idle
                   && !ext_devsel_n && boot_hit;
    end

    // Phase sequencing, capture and claim output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            devsel_n <= 1'b1;
            cap_addr <= '0;
            cap_cmd  <= '0;
            cap_lio  <= 1'b0;
            mode_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (!frame_n) begin
                        cap_addr <= ad;
                        cap_cmd  <= cbe_n;
                        cap_lio  <= local_io_hit;
                        mode_q   <= decode_subtr;
                        cnt      <= '0;
                        state    <= ST_DECODE;
                    end
                end
                ST_DECODE: begin
                    if (bus_idle) begin
                        state <= ST_IDLE;
                    end else if (!mode_q) begin
                        if (pos_hit) begin
                            devsel_n <= 1'b0;
                            state    <= ST_CLAIM;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end else if (!ext_devsel_n) begin
                        state <= ST_WAIT;
                    end else if (cnt == CNT_W'(SUB_LAUNCH_CNT)) begin
                        if (sub_ok) begin
                            devsel_n <= 1'b0;
                            state    <= ST_CLAIM;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_CLAIM: begin
                    if (last_done) begin
                        devsel_n <= 1'b1;
                        state    <= ST_WAIT;
                    end
                end
                default: begin
                    if (bus_idle) begin
                        state <= ST_IDLE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/pci_boot_status.sv
// Module: pci_boot_status
// Sticky status byte with write-one-to-clear bits. Each bit has its own
// set input, and a set beats a clear on the same edge. Only bits whose
// set input is ever driven can become 1.
module pci_boot_status #(
    parameter int STS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STS_W-1:0] set_vec,
    input  logic             wr_en,
    input  logic [STS_W-1:0] wdata,
    output logic [STS_W-1:0] sts
);

    generate
        for (genvar b = 0; b < STS_W; b++) begin : g_bit
            // One sticky bit: set has priority over a write-one clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sts[b] <= 1'b0;
                end else if (set_vec[b]) begin
                    sts[b] <= 1'b1;
                end else if (wr_en && wdata[b]) begin
                    sts[b] <= 1'b0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/pci_claim_ctl.sv
// Module: pci_claim_ctl (top)
// PCI target claim decoder: positive claim at medium timing, or
// subtractive claim at the fourth clock, plus a sticky boot status flag.
// Assumes the bus signals are already synchronous to clk.
module pci_claim_ctl
    import pci_claim_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                STS_W      = 8,
    parameter int                BOOT_BIT   = 2,
    parameter logic [ADDR_W-1:0] BOOT_BASE  = 32'hFFFF_0000,
    parameter logic [ADDR_W-1:0] BOOT_LIMIT = 32'hFFFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic              trdy_n,
    input  logic              ext_devsel_n,
    input  logic [ADDR_W-1:0] ad,
    input  logic [3:0]        cbe_n,
    input  logic              local_io_hit,
    input  logic              decode_subtr,
    input  logic [ADDR_W-1:0] win_base,
    input  logic [ADDR_W-1:0] win_limit,
    input  logic              sts_wr_en,
    input  logic [STS_W-1:0]  sts_wdata,
    output logic              devsel_n,
    output logic [STS_W-1:0]  status
);

    logic [ADDR_W-1:0] cap_addr;
    logic [3:0]        cap_cmd;
    logic              cap_lio;
    logic              mode_q;
    logic              pos_hit;
    logic              sub_ok;
    logic              boot_hit;
    logic              boot_set;
    logic [STS_W-1:0]  set_vec;

    // Route the boot event to its status bit; other bits have no source.
    always_comb begin
        set_vec           = '0;
        set_vec[BOOT_BIT] = boot_set;
    end

    pci_claim_decode #(
        .ADDR_W     (ADDR_W),
        .BOOT_BASE  (BOOT_BASE),
        .BOOT_LIMIT (BOOT_LIMIT)
    ) u_decode (
        .addr      (cap_addr),
        .cmd       (cap_cmd),
        .local_io  (cap_lio),
        .win_base  (win_base),
        .win_limit (win_limit),
        .pos_hit   (pos_hit),
        .sub_ok    (sub_ok),
        .boot_hit  (boot_hit)
    );

    pci_claim_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_n      (frame_n),
        .irdy_n       (irdy_n),
        .trdy_n       (trdy_n),
        .ext_devsel_n (ext_devsel_n),
        .ad           (ad),
        .cbe_n        (cbe_n),
        .local_io_hit (local_io_hit),
        .decode_subtr (decode_subtr),
        .pos_hit      (pos_hit),
        .sub_ok       (sub_ok),
        .boot_hit     (boot_hit),
        .cap_addr     (cap_addr),
        .cap_cmd      (cap_cmd),
        .cap_lio      (cap_lio),
        .mode_q       (mode_q),
        .devsel_n     (devsel_n),
        .boot_set     (boot_set)
    );

    pci_boot_status #(.STS_W(STS_W)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .wr_en   (sts_wr_en),
        .wdata   (sts_wdata),
        .sts     (status)
    );

endmodule

// File: rtl/pci_claim_chk.sv
// Module: pci_claim_chk
// Temporal checks on the claim decoder, attached to the top through bind.
module pci_claim_chk #(
    parameter int STS_W    = 8,
    parameter int BOOT_BIT = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_n,
    input logic             irdy_n,
    input logic             trdy_n,
    input logic             ext_devsel_n,
    input logic             devsel_n,
    input logic [STS_W-1:0] status,
    input logic             sts_wr_en,
    input logic [STS_W-1:0] sts_wdata,
    input logic             mode_q,
    input logic             boot_set
);

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (devsel_n && status == '0));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!devsel_n && !(frame_n && !irdy_n && !trdy_n)) |=> !devsel_n);

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!devsel_n && frame_n && !irdy_n && !trdy_n) |=> devsel_n);

    assert_ext_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && !ext_devsel_n && devsel_n) |=> devsel_n);

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status[BOOT_BIT] && !(sts_wr_en && sts_wdata[BOOT_BIT])) |=> status[BOOT_BIT]);

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status[BOOT_BIT] && sts_wr_en && sts_wdata[BOOT_BIT] && !boot_set)
        |=> !status[BOOT_BIT]);

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        boot_set |=> status[BOOT_BIT]);

endmodule

bind pci_claim_ctl pci_claim_chk #(.STS_W(STS_W), .BOOT_BIT(BOOT_BIT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_n      (frame_n),
    .irdy_n       (irdy_n),
    .trdy_n       (trdy_n),
    .ext_devsel_n (ext_devsel_n),
    .devsel_n     (devsel_n),
    .status       (status),
    .sts_wr_en    (sts_wr_en),
    .sts_wdata    (sts_wdata),
    .mode_q       (mode_q),
    .boot_set     (boot_set)
);

// File: tb/pci_claim_ctl_tb.sv
// Bench: sweeps mode, every command, local_io qualifier, window edge
// addresses and external DEVSEL# timing; expected values come from the
// requirement arithmetic only.
module pci_claim_ctl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, ext_devsel_n = 1'b1;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = '0;
    logic        local_io_hit = 1'b0, decode_subtr = 1'b0;
    logic [31:0] win_base = 32'h1000_0000, win_limit = 32'h1000_FFFF;
    logic        sts_wr_en = 1'b0;
    logic [7:0]  sts_wdata = '0;
    logic        devsel_n;
    logic [7:0]  status;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  exp_boot = 1'b0;
    bit  done = 1'b0;

    localparam logic [31:0] BOOT_LO = 32'hFFFF_0000;

    always #4 clk = ~clk;

    pci_claim_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .trdy_n(trdy_n), .ext_devsel_n(ext_devsel_n), .ad(ad), .cbe_n(cbe_n),
        .local_io_hit(local_io_hit), .decode_subtr(decode_subtr),
        .win_base(win_base), .win_limit(win_limit), .sts_wr_en(sts_wr_en),
        .sts_wdata(sts_wdata), .devsel_n(devsel_n), .status(status)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic bit claimable(input logic [3:0] c);
        return c == 2 || c == 3 || c == 6 || c == 7 || c == 10 || c == 11
            || c == 12 || c == 14 || c == 15;
    endfunction

    // One transaction with a single data phase.
    task automatic txn(input bit m, input logic [3:0] c, input logic [31:0] a,
                       input bit lio, input int ext_at, input int clr_at);
        bit elig, exp_claim, boot_cond;
        int cedge;
        elig      = claimable(c) && !((c == 2 || c == 3) && lio);
        exp_claim = m ? (elig && ext_at == 0) : (elig && a >= win_base && a <= win_limit);
        cedge     = m ? 3 : 1;
        boot_cond = m && ext_at >= 1 && (c == 6 || c == 12 || c == 14) && a >= BOOT_LO;
        frame_n = 1'b0; ad = a; cbe_n = c; local_io_hit = lio; decode_subtr = m;
        @(posedge clk); @(negedge clk);
        // R2: disturb the bus after the address phase
        ad = ~a; cbe_n = ~c; decode_subtr = ~m; local_io_hit = ~lio;
        frame_n = 1'b1; irdy_n = 1'b0;
        for (int k = 1; k <= 6; k++) begin
            ext_devsel_n = (ext_at != 0 && k >= ext_at) ? 1'b0 : 1'b1;
            sts_wr_en = (k == clr_at); sts_wdata = 8'h04;
            @(posedge clk);
            if (boot_cond && k == ext_at) exp_boot = 1'b1;
            else if (k == clr_at) exp_boot = 1'b0;
            @(negedge clk);
            sts_wr_en = 1'b0;
            // R3 R4 R5 R6 R7 R2: claim timing and decision
            check(devsel_n == !(exp_claim && k >= cedge),
                  m ? "R4/R5/R6/R7" : "R3/R6/R7", {31'd0, devsel_n},
                  {31'd0, !(exp_claim && k >= cedge)});
            // R9 R11: boot flag, set wins over simultaneous clear
            check(status == {5'd0, exp_boot, 2'd0}, "R9/R11", {24'd0, status},
                  {29'd0, exp_boot, 2'd0});
        end
        trdy_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check(devsel_n == 1'b1, "R8", {31'd0, devsel_n}, 32'd1);
        irdy_n = 1'b1; trdy_n = 1'b1; ext_devsel_n = 1'b1;
        @(posedge clk); @(negedge clk);
        // R10: write with bit 2 clear changes nothing, other bits stay 0
        sts_wr_en = 1'b1; sts_wdata = 8'hFB;
        @(posedge clk); @(negedge clk);
        sts_wr_en = 1'b0;
        check(status == {5'd0, exp_boot, 2'd0}, "R10", {24'd0, status}, {29'd0, exp_boot, 2'd0});
        sts_wr_en = 1'b1; sts_wdata = 8'h04;
        @(posedge clk); @(negedge clk);
        sts_wr_en = 1'b0; exp_boot = 1'b0;
        check(status == 8'h00, "R10", {24'd0, status}, 32'd0);
    endtask

    initial begin
        logic [31:0] pts [8];
        pts = '{32'h0FFF_FFFF, 32'h1000_0000, 32'h1000_0010, 32'h1000_FFFF,
                32'h1001_0000, 32'hFFFE_FFFF, 32'hFFFF_0000, 32'hFFFF_FFFC};
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check(devsel_n == 1'b1, "R1", {31'd0, devsel_n}, 32'd1);
        check(status == 8'h00, "R1", {24'd0, status}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int m = 0; m < 2; m++)
            for (int c = 0; c < 16; c++)
                for (int l = 0; l < 2; l++)
                    for (int p = 0; p < 8; p++)
                        for (int e = 0; e < 4; e++)
                            txn(m[0], c[3:0], pts[p], l[0], e, (e == 2) ? 2 : 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        for (int cyc = 0; cyc < 200000; cyc++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual %0d expected %0d", 200000, 0);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule